// File: doc/BRIEF.md
# Halt Request and Bus-Status Controller

This block sits beside a small 8-bit processor core and handles the external request that suspends it. The request pin is asynchronous, so it is first brought into the clock domain through a flop chain. A rising edge of the synchronized level is remembered in a sticky "assert pending" flag. A falling edge is remembered in a sticky "release pending" flag, but only when an assert is already pending. Neither flag acts at once. Both are acted on only when the core signals that an instruction has finished, so the core is never stopped part way through an instruction.

From the halted state and a SYNC-wait flag, the block drives two bus-status outputs: bus-available (`ba_o`) and bus-state (`bs_o`). The SYNC-wait flag is set by a pulse from the core when it executes SYNC, and cleared by a pulse when an interrupt ends the wait. The outputs encode three conditions. Running is BA=0, BS=0. SYNC wait is BA=1, BS=0. Halted is BA=1, BS=1. These are registered state, so they change once on entry to a condition and then hold. A parameter selects whether a release is committed only at an instruction-boundary strobe (the default) or on any clock cycle while halted.

Top module: `halt_bus_ctl`

## Requirements
- R1: A rising edge of the synchronized halt request (after `SYNC_STAGES` flops) sets the assert-pending flag. Without an instruction-boundary strobe (`insn_end_i`=1), the block does not enter the halted state.
- R2: A falling edge of the synchronized request sets the release-pending flag only while assert-pending is set. A falling edge or a low level with no pending assert changes no output.
- R3: At a boundary strobe while running, with assert pending and no release pending, `halted_o`, `ba_o` and `bs_o` go to 1 on the next cycle.
- R4: A boundary strobe with both flags set clears both flags. If halted, the block leaves the halted state. A request that is raised and dropped between two boundaries therefore causes no halt. While halted with the default parameter, the release waits for a boundary strobe.
- R5: While halted, a boundary strobe without a pending release has no effect. SYNC-execute and SYNC-exit pulses leave the outputs at BA=1, BS=1, but they still update the SYNC-wait flag.
- R6: On leaving the halted state, `bs_o` goes to 0. `ba_o` becomes 1 if the SYNC-wait flag is set, and 0 otherwise.
- R7: While running, a SYNC-execute pulse gives BA=1, BS=0 on the next cycle, and a SYNC-exit pulse gives BA=0, BS=0. When both pulses arrive in the same cycle, SYNC-execute wins.
- R8: Reset is synchronous and active high, and is held for at least `SYNC_STAGES`+1 cycles. If the synchronized request is high during reset, the block leaves reset with assert pending, halted, and BA=BS=1. Otherwise both flags and the SYNC-wait flag are cleared and BA=BS=0.
- R9: The combination BA=0, BS=1 never occurs, and `halted_o` always equals `bs_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| halt_req_i | input | 1 | Asynchronous halt request, level |
| insn_end_i | input | 1 | Instruction-boundary strobe from the core |
| sync_exec_i | input | 1 | Pulse: core executed SYNC |
| sync_exit_i | input | 1 | Pulse: interrupt ended the SYNC wait |
| halted_o | output | 1 | Core must stay suspended |
| ba_o | output | 1 | Bus-available status |
| bs_o | output | 1 | Bus-state status |

## Verification
The embedded properties check on every cycle that the bus-status pair stays in a legal encoding that agrees with the halted flag. They also check that a release flag never exists without an assert flag, and that entry and release happen only at the cycle after a qualifying boundary. Only the bench scenarios can show the deferred behaviour across a sequence of events. These include a request pulse absorbed between two boundaries, SYNC pulses that arrive while halted and decide the BA level at release, and the two outcomes of reset with the request high or low.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

   // Bus-status encoding: bit 1 drives BA, bit 0 drives BS.
   typedef enum logic [1:0] {
      BUS_RUN  = 2'b00,
      BUS_SYNC = 2'b10,
      BUS_HALT = 2'b11
   } bus_state_t;

   localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/hbc_sync.sv
// Multi-flop synchronizer for one asynchronous level.
module hbc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic d_i,
   output logic q_o
);
   import hbc_pkg::*;

   if (STAGES < MIN_SYNC_STAGES) begin : g_bad_stages
      $error("hbc_sync: STAGES must be at least %0d", MIN_SYNC_STAGES);
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/hbc_req_latch.sv
// Edge detection on the synchronized request and the two sticky flags.
module hbc_req_latch (
   input  logic clk,
   input  logic rst_i,
   input  logic lvl_i,     // synchronized request level
   input  logic clear_i,   // commit: drop both flags
   output logic on_o,
   output logic off_o
);
   logic lvl_d_q;
   logic on_q;
   logic off_q;
   logic rise;
   logic fall;
   logic on_kept;
   logic off_kept;

   assign rise     = lvl_i & ~lvl_d_q;
   assign fall     = ~lvl_i & lvl_d_q;
   assign on_kept  = clear_i ? 1'b0 : on_q;
   assign off_kept = clear_i ? 1'b0 : off_q;

   always_ff @(posedge clk) begin
      if (rst_i) begin
         // A request already high at reset remains pending; all else is dropped.
         lvl_d_q <= lvl_i;
         on_q    <= lvl_i;
         off_q   <= 1'b0;
      end else begin
         lvl_d_q <= lvl_i;
         on_q    <= on_kept | rise;
         off_q   <= off_kept | (fall & on_kept);
      end
   end

   assign on_o  = on_q;
   assign off_o = off_q;

   // R2: a release can only be pending on top of a pending assert
   p_off_needs_on_r2: assert property (@(posedge clk) disable iff (rst_i)
      off_q |-> on_q);

   // R1: a synchronized rising edge always leaves assert pending
   p_rise_sets_on_r1: assert property (@(posedge clk) disable iff (rst_i)
      rise |=> on_q);

endmodule

// File: rtl/hbc_halt_ctrl.sv
// Halted state; commits the sticky flags at the permitted moments.
module hbc_halt_ctrl #(
   parameter bit RELEASE_ANY_CYCLE = 1'b0
) (
   input  logic clk,
   input  logic rst_i,
   input  logic lvl_i,       // synchronized request, used at reset
   input  logic insn_end_i,
   input  logic on_i,
   input  logic off_i,
   output logic halted_o,
   output logic enter_o,
   output logic leave_o,
   output logic clear_o
);
   logic halted_q;
   logic rel_slot;
   logic eval;

   if (RELEASE_ANY_CYCLE) begin : g_rel_any
      assign rel_slot = 1'b1;
   end else begin : g_rel_bound
      assign rel_slot = insn_end_i;
   end

   // While halted, the strobe serves only the release decision.
   assign eval    = halted_q ? rel_slot : insn_end_i;
   assign enter_o = ~halted_q & eval & on_i & ~off_i;
   assign leave_o = halted_q & eval & on_i & off_i;
   assign clear_o = eval & on_i & off_i;

   always_ff @(posedge clk) begin
      if (rst_i) begin
         halted_q <= lvl_i;
      end else if (enter_o) begin
         halted_q <= 1'b1;
      end else if (leave_o) begin
         halted_q <= 1'b0;
      end
   end

   assign halted_o = halted_q;

   // R3: boundary with assert only, while running, halts next cycle
   p_enter_r3: assert property (@(posedge clk) disable iff (rst_i)
      (!halted_q && insn_end_i && on_i && !off_i) |=> halted_q);

   // R1: no halt entry without a boundary strobe
   p_no_entry_r1: assert property (@(posedge clk) disable iff (rst_i)
      (!halted_q && !insn_end_i) |=> !halted_q);

   // R4: boundary with both flags while halted releases
   p_release_r4: assert property (@(posedge clk) disable iff (rst_i)
      (halted_q && insn_end_i && on_i && off_i) |=> !halted_q);

   // R5: without a pending release the halted state holds
   p_hold_r5: assert property (@(posedge clk) disable iff (rst_i)
      (halted_q && !off_i) |=> halted_q);

endmodule

// File: rtl/hbc_bus_status.sv
// SYNC-wait tracking and the registered BA/BS encoding.
module hbc_bus_status (
   input  logic clk,
   input  logic rst_i,
   input  logic lvl_i,        // synchronized request, used at reset
   input  logic halted_i,
   input  logic enter_i,
   input  logic leave_i,
   input  logic sync_exec_i,
   input  logic sync_exit_i,
   output logic ba_o,
   output logic bs_o
);
   import hbc_pkg::*;

   bus_state_t state_q;
   bus_state_t state_d;
   logic       sync_q;
   logic       sync_d;

   // SYNC-execute wins over exit in the same cycle.
   always_comb begin
      if (sync_exec_i)      sync_d = 1'b1;
      else if (sync_exit_i) sync_d = 1'b0;
      else                  sync_d = sync_q;
   end

   always_comb begin
      if (enter_i)                       state_d = BUS_HALT;
      else if (halted_i && !leave_i)     state_d = state_q;   // frozen while halted
      else if (sync_d)                   state_d = BUS_SYNC;
      else                               state_d = BUS_RUN;
   end

   always_ff @(posedge clk) begin
      if (rst_i) begin
         sync_q  <= 1'b0;
         state_q <= lvl_i ? BUS_HALT : BUS_RUN;
      end else begin
         sync_q  <= sync_d;
         state_q <= state_d;
      end
   end

   assign ba_o = state_q[1];
   assign bs_o = state_q[0];

   // R7: SYNC executed while running shows BA high, BS low
   p_sync_enter_r7: assert property (@(posedge clk) disable iff (rst_i)
      (!halted_i && !enter_i && sync_exec_i) |=> (ba_o && !bs_o));

   // R7: SYNC exit alone while running returns both low
   p_sync_exit_r7: assert property (@(posedge clk) disable iff (rst_i)
      (!halted_i && !enter_i && sync_exit_i && !sync_exec_i) |=> (!ba_o && !bs_o));

   // R6: leaving the halt always drops BS
   p_leave_bs_r6: assert property (@(posedge clk) disable iff (rst_i)
      leave_i |=> !bs_o);

   // R5: while halted and not leaving, outputs hold
   p_frozen_r5: assert property (@(posedge clk) disable iff (rst_i)
      (halted_i && !leave_i) |=> ($stable(ba_o) && $stable(bs_o)));

endmodule

// File: rtl/halt_bus_ctl.sv
// Top: halt request capture, halted state, BA/BS status.
module halt_bus_ctl #(
   parameter int unsigned SYNC_STAGES       = 2,
   parameter bit          RELEASE_ANY_CYCLE = 1'b0
) (
   input  logic clk,
   input  logic rst_i,
   input  logic halt_req_i,
   input  logic insn_end_i,
   input  logic sync_exec_i,
   input  logic sync_exit_i,
   output logic halted_o,
   output logic ba_o,
   output logic bs_o
);
   import hbc_pkg::*;

   if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_cfg
      $error("halt_bus_ctl: SYNC_STAGES too small");
   end

   logic req_lvl;
   logic on_flag;
   logic off_flag;
   logic enter;
   logic leave;
   logic clear;

   hbc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .d_i (halt_req_i),
      .q_o (req_lvl)
   );

   hbc_req_latch u_latch (
      .clk     (clk),
      .rst_i   (rst_i),
      .lvl_i   (req_lvl),
      .clear_i (clear),
      .on_o    (on_flag),
      .off_o   (off_flag)
   );

   hbc_halt_ctrl #(.RELEASE_ANY_CYCLE(RELEASE_ANY_CYCLE)) u_ctrl (
      .clk        (clk),
      .rst_i      (rst_i),
      .lvl_i      (req_lvl),
      .insn_end_i (insn_end_i),
      .on_i       (on_flag),
      .off_i      (off_flag),
      .halted_o   (halted_o),
      .enter_o    (enter),
      .leave_o    (leave),
      .clear_o    (clear)
   );

   hbc_bus_status u_bus (
      .clk         (clk),
      .rst_i       (rst_i),
      .lvl_i       (req_lvl),
      .halted_i    (halted_o),
      .enter_i     (enter),
      .leave_i     (leave),
      .sync_exec_i (sync_exec_i),
      .sync_exit_i (sync_exit_i),
      .ba_o        (ba_o),
      .bs_o        (bs_o)
   );

   // R9: status pair legal and consistent with the halted flag
   p_legal_enc_r9: assert property (@(posedge clk) disable iff (rst_i)
      !(bs_o && !ba_o));

   p_halt_match_r9: assert property (@(posedge clk) disable iff (rst_i)
      halted_o == bs_o);

endmodule

// File: tb/halt_bus_ctl_test.sv
module halt_bus_ctl_test;

   localparam time CLK_PERIOD = 10ns;
   localparam int  SETTLE     = 4;
   localparam int  NVEC       = 21;

   // Row: {req, insn_end, sync_exec, sync_exit, exp_halted, exp_ba, exp_bs}
   localparam logic [6:0] VEC [0:NVEC-1] = '{
      7'b0000_000,   //  0 R8 idle after reset
      7'b1000_000,   //  1 R1 request seen, no boundary yet
      7'b1100_111,   //  2 R3 boundary enters halt
      7'b1100_111,   //  3 R5 boundary while halted, no release pending
      7'b0000_111,   //  4 R4 release waits for boundary
      7'b0100_000,   //  5 R4 boundary releases
      7'b0100_000,   //  6 R2 low level without pending assert
      7'b0010_010,   //  7 R7 SYNC wait
      7'b1100_111,   //  8 R3 halt from SYNC wait
      7'b0100_010,   //  9 R6 release back into SYNC wait
      7'b0001_000,   // 10 R7 SYNC exit
      7'b1100_111,   // 11 R3
      7'b1010_111,   // 12 R5 SYNC exec while halted: outputs hold
      7'b0100_010,   // 13 R6 BA follows SYNC set during halt
      7'b0001_000,   // 14 R7
      7'b1100_111,   // 15 R3
      7'b1010_111,   // 16 R5
      7'b1001_111,   // 17 R5 SYNC exit while halted: outputs hold
      7'b0100_000,   // 18 R6 SYNC cleared during halt: BA low
      7'b0011_010,   // 19 R7 exec wins over exit
      7'b0001_000    // 20 R7
   };

   logic clk = 1'b0;
   logic rst_i = 1'b1;
   logic halt_req_i = 1'b0;
   logic insn_end_i = 1'b0;
   logic sync_exec_i = 1'b0;
   logic sync_exit_i = 1'b0;
   logic halted_o, ba_o, bs_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   halt_bus_ctl uut (
      .clk         (clk),
      .rst_i       (rst_i),
      .halt_req_i  (halt_req_i),
      .insn_end_i  (insn_end_i),
      .sync_exec_i (sync_exec_i),
      .sync_exit_i (sync_exit_i),
      .halted_o    (halted_o),
      .ba_o        (ba_o),
      .bs_o        (bs_o)
   );

   task automatic check(input string tag, input logic [2:0] exp);
      logic [2:0] act;
      act = {halted_o, ba_o, bs_o};
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: {halted,ba,bs} = %b, expected %b", tag, act, exp);
      end
   endtask

   // Set request level, let it settle, pulse strobes for one cycle.
   task automatic apply(input logic req, input logic b, input logic se, input logic sx);
      @(negedge clk);
      halt_req_i = req;
      repeat (SETTLE) @(negedge clk);
      insn_end_i  = b;
      sync_exec_i = se;
      sync_exit_i = sx;
      @(negedge clk);
      insn_end_i  = 1'b0;
      sync_exec_i = 1'b0;
      sync_exit_i = 1'b0;
   endtask

   task automatic do_reset(input logic req);
      @(negedge clk);
      halt_req_i = req;
      rst_i = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung, expected done");
      finish_run();
   end

   initial begin
      // R8: reset with request low
      do_reset(1'b0);
      check("R8 in reset, request low", 3'b000);
      rst_i = 1'b0;
      @(negedge clk);
      check("R8 after reset, request low", 3'b000);

      for (int i = 0; i < NVEC; i++) begin
         apply(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3]);
         check($sformatf("vector %0d", i), VEC[i][2:0]);
      end

      // R4: request raised and dropped between boundaries is absorbed
      apply(1'b1, 1'b0, 1'b0, 1'b0);
      apply(1'b0, 1'b1, 1'b0, 1'b0);
      check("R4 short request absorbed", 3'b000);
      apply(1'b0, 1'b1, 1'b0, 1'b0);
      check("R4 flags cleared, second boundary", 3'b000);
      // R2: no further effect from low request with nothing pending
      apply(1'b0, 1'b1, 1'b0, 1'b0);
      check("R2 fall without pending assert", 3'b000);

      // R8: reset with request held high ends halted
      do_reset(1'b1);
      check("R8 in reset, request high", 3'b111);
      rst_i = 1'b0;
      @(negedge clk);
      check("R8 after reset, request high", 3'b111);
      apply(1'b0, 1'b1, 1'b0, 1'b0);
      check("R8 pending halt released after reset", 3'b000);

      // R8: reset drops pending assert and release flags
      apply(1'b1, 1'b0, 1'b0, 1'b0);
      apply(1'b0, 1'b0, 1'b0, 1'b0);
      do_reset(1'b0);
      rst_i = 1'b0;
      @(negedge clk);
      check("R8 reset clears pending flags", 3'b000);
      apply(1'b0, 1'b1, 1'b0, 1'b0);
      check("R8 boundary after reset, nothing pending", 3'b000);

      // R1: assert pending across many idle cycles stays deferred
      apply(1'b1, 1'b0, 1'b0, 1'b0);
      repeat (10) @(negedge clk);
      check("R1 no halt without boundary", 3'b000);
      apply(1'b1, 1'b1, 1'b0, 1'b0);
      check("R3 late boundary enters halt", 3'b111);

      finish_run();
   end

endmodule